// File: doc/BRIEF.md
# Reversing Motor Starter Interlock

This block controls a motor that can turn in two directions. It has three button levels as inputs, already debounced: a stop contact and two run buttons. It drives two contactor enables, one for forward rotation and one for reverse. The stop contact is wired normally closed, so the raw line reads 1 while stop is not pressed. A short press of a run button turns on that direction. The enable then holds itself on through its own feedback until stop is pressed.

Each direction blocks the other. A run request for the opposite direction while the motor is turning is dropped, not stored for later. To change direction, stop must be pressed first. Both enables are registered and are updated once per clock cycle. The block's reset is asserted asynchronously and released on the clock.

Top module: `motor_rev_starter`

## Requirements
- R1: While reset is asserted, and in the cycles that follow its release with no run button pressed, both `fwd_on_o` and `rev_on_o` are 0.
- R2: The stop line is active low (`stop_nc_i` = 0 means stop pressed). An enable can be 1 only if `stop_nc_i` was 1 at the preceding clock edge.
- R3: From standstill, with `stop_nc_i` = 1, `fwd_btn_i` = 1 and `rev_btn_i` = 0 at a clock edge, `fwd_on_o` is 1 after that edge.
- R4: Once an enable is 1, it stays 1 on every following edge where `stop_nc_i` is 1, whatever the run buttons do.
- R5: From standstill, with `stop_nc_i` = 1, `rev_btn_i` = 1 and `fwd_btn_i` = 0 at a clock edge, `rev_on_o` is 1 after that edge. It then holds as in R4.
- R6: While one enable is 1, pressing the other direction's button leaves the other enable at 0. Pressing both buttons together changes nothing either.
- R7: A stop press wins over any run button in the same cycle. Both enables are 0 after that clock edge.
- R8: After a stop has cleared a running direction, a press of the opposite direction's button is accepted and latches that direction.
- R9: From standstill, if both run buttons are 1 at the same edge, both enables stay 0.
- R10: `fwd_on_o` and `rev_on_o` are never both 1 in the same cycle, for any sequence of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low. Asserted asynchronously, released on the clock |
| stop_nc_i | input | 1 | Stop contact, normally closed: 1 = not pressed, 0 = pressed |
| fwd_btn_i | input | 1 | Forward run button, 1 = pressed |
| rev_btn_i | input | 1 | Reverse run button, 1 = pressed |
| fwd_on_o | output | 1 | Forward contactor enable, registered |
| rev_on_o | output | 1 | Reverse contactor enable, registered |

## Verification
The properties assume that the three button levels are already debounced and synchronous to `clk`, so each level is steady for a whole cycle. The bench meets this by changing inputs only on the falling edge. The properties also assume that the first cycles after reset release are quiet. The bench therefore holds every button idle until the internal reset has been released. It then drives directed sequences for latching, holding, interlock, stop priority and direction change. After that it drives a long random run in which stop is pressed only rarely, so that held states last a long time and the interlock is exercised often.

// File: rtl/motor_rev_pkg.sv
package motor_rev_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_W   = $clog2(NUM_DIR);

  typedef enum logic [DIR_W-1:0] {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  typedef logic [NUM_DIR-1:0] dir_vec_t;
endpackage

// File: rtl/motor_rev_rst_sync.sv
module motor_rev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/motor_rev_rung.sv
module motor_rev_rung (
  input  logic stop_ok,
  input  logic own_btn,
  input  logic other_btn,
  input  logic own_q,
  input  logic other_q,
  output logic own_nxt
);
  logic start_req;
  logic seal_in;
  logic blocked;

  always_comb begin
    start_req = own_btn & ~other_btn;
    seal_in   = own_q;
    blocked   = other_q;
    own_nxt   = stop_ok & ~blocked & (seal_in | start_req);
  end
endmodule

// File: rtl/motor_rev_starter.sv
module motor_rev_starter
  import motor_rev_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_nc_i,
  input  logic fwd_btn_i,
  input  logic rev_btn_i,
  output logic fwd_on_o,
  output logic rev_on_o
);
  logic     rst_sync_n;
  dir_vec_t btn_v;
  dir_vec_t coil_q;
  dir_vec_t coil_nxt;
  logic     coil_en;

  motor_rev_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    btn_v          = '0;
    btn_v[DIR_FWD] = fwd_btn_i;
    btn_v[DIR_REV] = rev_btn_i;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_rung
    localparam int OTHER = NUM_DIR - 1 - d;
    motor_rev_rung u_rung (
      .stop_ok   (stop_nc_i),
      .own_btn   (btn_v[d]),
      .other_btn (btn_v[OTHER]),
      .own_q     (coil_q[d]),
      .other_q   (coil_q[OTHER]),
      .own_nxt   (coil_nxt[d])
    );
  end

  always_comb begin
    coil_en = |(coil_q ^ coil_nxt);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  coil_q <= '0;
    else if (coil_en) coil_q <= coil_nxt;
  end

  assign fwd_on_o = coil_q[DIR_FWD];
  assign rev_on_o = coil_q[DIR_REV];
endmodule

// File: rtl/motor_rev_starter_chk.sv
module motor_rev_starter_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_nc_i,
  input logic fwd_btn_i,
  input logic rev_btn_i,
  input logic fwd_on_o,
  input logic rev_on_o
);
  assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_on_o && rev_on_o));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_nc_i |=> (!fwd_on_o && !rev_on_o));

  assert_on_needs_stop_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_on_o || rev_on_o) |-> $past(stop_nc_i));

  assert_fwd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_on_o) |-> ($past(fwd_btn_i) && !$past(rev_btn_i)));

  assert_rev_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_on_o) |-> ($past(rev_btn_i) && !$past(fwd_btn_i)));

  assert_fwd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_on_o && stop_nc_i) |=> fwd_on_o);

  assert_rev_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_on_o && stop_nc_i) |=> rev_on_o);

  assert_interlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_on_o |=> !rev_on_o);

  assert_both_pressed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_on_o && !rev_on_o && fwd_btn_i && rev_btn_i) |=> (!fwd_on_o && !rev_on_o));
endmodule

bind motor_rev_starter motor_rev_starter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_nc_i (stop_nc_i),
  .fwd_btn_i (fwd_btn_i),
  .rev_btn_i (rev_btn_i),
  .fwd_on_o  (fwd_on_o),
  .rev_on_o  (rev_on_o)
);

// File: tb/tb_motor_rev_starter.sv
module tb_motor_rev_starter;
  logic clk;
  logic rst_n;
  logic stop_nc_i;
  logic fwd_btn_i;
  logic rev_btn_i;
  logic fwd_on_o;
  logic rev_on_o;

  int n_checks = 0;
  int n_fails  = 0;
  int model_state = 0; // 0 idle, 1 forward, 2 reverse

  motor_rev_starter dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_nc_i (stop_nc_i),
    .fwd_btn_i (fwd_btn_i),
    .rev_btn_i (rev_btn_i),
    .fwd_on_o  (fwd_on_o),
    .rev_on_o  (rev_on_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_outputs(input string tag);
    logic exp_f;
    logic exp_r;
    exp_f = (model_state == 1);
    exp_r = (model_state == 2);
    n_checks++;
    if (fwd_on_o !== exp_f || rev_on_o !== exp_r) begin
      n_fails++;
      $display("FAIL %s: fwd/rev = %b%b, expected %b%b", tag, fwd_on_o, rev_on_o, exp_f, exp_r);
    end
    n_checks++;
    if (fwd_on_o === 1'b1 && rev_on_o === 1'b1) begin
      n_fails++;
      $display("FAIL R10: fwd/rev = %b%b, expected not both 1", fwd_on_o, rev_on_o);
    end
  endtask

  task automatic step(input logic s, input logic f, input logic r, input string tag);
    @(negedge clk);
    stop_nc_i = s;
    fwd_btn_i = f;
    rev_btn_i = r;
    @(posedge clk);
    if (!s) model_state = 0;
    else if (model_state == 0) begin
      if (f && !r)      model_state = 1;
      else if (r && !f) model_state = 2;
    end
    #2;
    check_outputs(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    stop_nc_i = 1'b1;
    fwd_btn_i = 1'b0;
    rev_btn_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R1");

    step(1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b1, "R9");
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, "R8");

    for (int i = 0; i < 4000; i++) begin
      logic s;
      logic f;
      logic r;
      s = (($urandom % 8) != 0);
      f = $urandom % 2;
      r = $urandom % 2;
      step(s, f, r, "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule